// File: doc/BRIEF.md
# AXI ID Masked Event Filter

This block sits beside an AXI port and watches three of its channels without driving any of them: the read address channel, the write address channel and the read data channel. Each time one of these channels completes a handshake, the block compares the transfer ID against a programmed ID. A programmed mask chooses which ID bits take part in the compare. When the compare succeeds and the event kind is enabled, the block raises a one-cycle pulse. The three pulses (read transactions, write transactions and read data beats) drive the event inputs of three counters in a performance monitor. That monitor selects these pulses with event code 73, on counters 2, 3 and 4 respectively.

Software programs the block through two 32-bit words on a simple write port. The control word holds three enable bits and the ID mask. The match word holds the reference ID. All three event kinds share the same mask and reference ID. The enable bits turn each kind on or off on its own.

Top module: `axi_id_event_filter`

## Requirements
- R1: After reset, all three event outputs are low, all three enables are clear, and the mask and reference ID are zero.
- R2: A write to offset 0x00 loads the control word: bit 31 enables read-transaction events, bit 30 enables write-transaction events, bit 29 enables read-beat events, and bits ID_W-1:0 hold the mask. A write to offset 0x04 loads the reference ID from bits ID_W-1:0. All other bits of these words have no effect, and writes to any other offset have no effect.
- R3: An ID matches when it equals the reference ID in every bit position where the mask bit is 1. ID bits whose mask bit is 0 are ignored, so an all-zero mask matches every ID.
- R4: A read address handshake (arValid and arReady both high) with a matching arId, while read-transaction events are enabled, makes evRdTrans high for exactly the following cycle.
- R5: A write address handshake with a matching awId, while write-transaction events are enabled, makes evWrTrans high for exactly the following cycle.
- R6: Every read data handshake with a matching rId, while read-beat events are enabled, makes evRdBeat high in the following cycle. Back-to-back beats therefore give back-to-back pulses.
- R7: A channel that has valid without ready, or ready without valid, produces no pulse.
- R8: While an event kind's enable is clear, its output stays low whatever the traffic.
- R9: A configuration write takes effect for handshakes in the cycle after the write. A handshake in the same cycle as the write is judged against the old settings.
- R10: The three event kinds are evaluated independently. Handshakes on several channels in the same cycle give pulses on all the qualifying outputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | ADDR_W | Configuration byte offset |
| cfgWdata | input | 32 | Configuration write data |
| arValid | input | 1 | Read address valid (observed) |
| arReady | input | 1 | Read address ready (observed) |
| arId | input | ID_W | Read address ID |
| awValid | input | 1 | Write address valid (observed) |
| awReady | input | 1 | Write address ready (observed) |
| awId | input | ID_W | Write address ID |
| rValid | input | 1 | Read data valid (observed) |
| rReady | input | 1 | Read data ready (observed) |
| rId | input | ID_W | Read data ID |
| evRdTrans | output | 1 | Filtered read-transaction pulse |
| evWrTrans | output | 1 | Filtered write-transaction pulse |
| evRdBeat | output | 1 | Filtered read-beat pulse |

## Verification
The hardest case to reach from the ports is the masked compare across every combination of mask, reference ID and incoming ID. In normal traffic only a handful of these combinations ever occur. The bench builds the block with a 4-bit ID and sweeps every mask against every reference ID. For each setting it presents every incoming ID on all three channels at once, giving each channel a different offset, so that in the same cycle some channels match and others do not. A second hard case is a reconfiguration that lands in the same cycle as a handshake. The bench reaches it by raising the write strobe together with a valid and ready pair.

// File: rtl/axiflt_pkg.sv
package axiflt_pkg;
  localparam int CFG_W = 32;
  localparam int N_KIND = 3;
  // control word enable positions
  localparam int EN_RD_TRANS_BIT = 31;
  localparam int EN_WR_TRANS_BIT = 30;
  localparam int EN_RD_BEAT_BIT = 29;
  localparam int LOW_EN_BIT = 29;
  // byte offsets of the two words
  localparam logic [7:0] CTL_OFS = 8'h00;
  localparam logic [7:0] MATCH_OFS = 8'h04;

  // one bit per event kind, read transactions in bit 0
  typedef struct packed {
    logic rdBeat;
    logic wrTrans;
    logic rdTrans;
  } kindVec_t;
endpackage

// File: rtl/axiflt_idcmp.sv
module axiflt_idcmp #(
  parameter int ID_W = 18
) (
  input  logic [ID_W-1:0] id,
  input  logic [ID_W-1:0] refId,
  input  logic [ID_W-1:0] mask,
  output logic            match
);
  logic [ID_W-1:0] diffBits;

  always_comb begin
    diffBits = (id ^ refId) & mask;
    match = ~|diffBits;
  end
endmodule

// File: rtl/axiflt_ctrl.sv
module axiflt_ctrl
  import axiflt_pkg::*;
#(
  parameter int ID_W = 18,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [CFG_W-1:0]  cfgWdata,
  output kindVec_t          enStrobe,
  output logic [ID_W-1:0]   idMask,
  output logic [ID_W-1:0]   matchId
);
  localparam logic [ADDR_W-1:0] CTL_A = ADDR_W'(CTL_OFS);
  localparam logic [ADDR_W-1:0] MATCH_A = ADDR_W'(MATCH_OFS);

  logic ctlHit;
  logic matchHit;
  logic unusedCfgBits;

  assign ctlHit = cfgWe && (cfgAddr == CTL_A);
  assign matchHit = cfgWe && (cfgAddr == MATCH_A);
  assign unusedCfgBits = ^cfgWdata[LOW_EN_BIT-1:ID_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enStrobe <= '0;
      idMask <= '0;
    end else if (ctlHit) begin
      enStrobe.rdTrans <= cfgWdata[EN_RD_TRANS_BIT];
      enStrobe.wrTrans <= cfgWdata[EN_WR_TRANS_BIT];
      enStrobe.rdBeat <= cfgWdata[EN_RD_BEAT_BIT];
      idMask <= cfgWdata[ID_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      matchId <= '0;
    end else if (matchHit) begin
      matchId <= cfgWdata[ID_W-1:0];
    end
  end
endmodule

// File: rtl/axiflt_datapath.sv
module axiflt_datapath
  import axiflt_pkg::*;
#(
  parameter int ID_W = 18
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  kindVec_t                    enStrobe,
  input  logic [ID_W-1:0]             idMask,
  input  logic [ID_W-1:0]             matchId,
  input  logic [N_KIND-1:0]           chValid,
  input  logic [N_KIND-1:0]           chReady,
  input  logic [N_KIND-1:0][ID_W-1:0] chId,
  output kindVec_t                    evQ
);
  logic [N_KIND-1:0] enVec;
  logic [N_KIND-1:0] idMatch;
  logic [N_KIND-1:0] qualify;
  logic [N_KIND-1:0] evVec;

  assign enVec = enStrobe;

  for (genvar k = 0; k < N_KIND; k++) begin : g_kind
    axiflt_idcmp #(.ID_W(ID_W)) u_cmp (
      .id   (chId[k]),
      .refId(matchId),
      .mask (idMask),
      .match(idMatch[k])
    );

    assign qualify[k] = chValid[k] && chReady[k] && enVec[k] && idMatch[k];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) evVec[k] <= 1'b0;
      else evVec[k] <= qualify[k];
    end
  end

  assign evQ = kindVec_t'(evVec);
endmodule

// File: rtl/axi_id_event_filter.sv
module axi_id_event_filter
  import axiflt_pkg::*;
#(
  parameter int ID_W = 18,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [31:0]       cfgWdata,
  input  logic              arValid,
  input  logic              arReady,
  input  logic [ID_W-1:0]   arId,
  input  logic              awValid,
  input  logic              awReady,
  input  logic [ID_W-1:0]   awId,
  input  logic              rValid,
  input  logic              rReady,
  input  logic [ID_W-1:0]   rId,
  output logic              evRdTrans,
  output logic              evWrTrans,
  output logic              evRdBeat
);
  kindVec_t enStrobe;
  kindVec_t evQ;
  logic [N_KIND-1:0] enVec;
  logic [ID_W-1:0] idMask;
  logic [ID_W-1:0] matchId;
  logic [N_KIND-1:0] chValid;
  logic [N_KIND-1:0] chReady;
  logic [N_KIND-1:0][ID_W-1:0] chId;

  assign enVec = enStrobe;
  assign chValid = {rValid, awValid, arValid};
  assign chReady = {rReady, awReady, arReady};
  assign chId = {rId, awId, arId};

  axiflt_ctrl #(.ID_W(ID_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .cfgWe   (cfgWe),
    .cfgAddr (cfgAddr),
    .cfgWdata(cfgWdata),
    .enStrobe(enStrobe),
    .idMask  (idMask),
    .matchId (matchId)
  );

  axiflt_datapath #(.ID_W(ID_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .enStrobe(enStrobe),
    .idMask  (idMask),
    .matchId (matchId),
    .chValid (chValid),
    .chReady (chReady),
    .chId    (chId),
    .evQ     (evQ)
  );

  assign evRdTrans = evQ.rdTrans;
  assign evWrTrans = evQ.wrTrans;
  assign evRdBeat = evQ.rdBeat;
endmodule

// File: rtl/axiflt_checker.sv
module axiflt_checker #(
  parameter int ID_W = 18
) (
  input logic            clk,
  input logic            rstN,
  input logic            arValid,
  input logic            arReady,
  input logic [ID_W-1:0] arId,
  input logic            awValid,
  input logic            awReady,
  input logic [ID_W-1:0] awId,
  input logic            rValid,
  input logic            rReady,
  input logic [ID_W-1:0] rId,
  input logic [2:0]      enVec,
  input logic [ID_W-1:0] idMask,
  input logic [ID_W-1:0] matchId,
  input logic            evRdTrans,
  input logic            evWrTrans,
  input logic            evRdBeat
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rstN |=> (!evRdTrans && !evWrTrans && !evRdBeat));

  assert_rd_trans_hit_R4: assert property (@(posedge clk) disable iff (!rstN)
    (arValid && arReady && enVec[0] && (((arId ^ matchId) & idMask) == '0)) |=> evRdTrans);

  assert_wr_trans_hit_R5: assert property (@(posedge clk) disable iff (!rstN)
    (awValid && awReady && enVec[1] && (((awId ^ matchId) & idMask) == '0)) |=> evWrTrans);

  assert_rd_beat_hit_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rValid && rReady && enVec[2] && (((rId ^ matchId) & idMask) == '0)) |=> evRdBeat);

  assert_rd_needs_handshake_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(arValid && arReady) |=> !evRdTrans);

  assert_wr_needs_handshake_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(awValid && awReady) |=> !evWrTrans);

  assert_beat_needs_handshake_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(rValid && rReady) |=> !evRdBeat);

  assert_disabled_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    (enVec == 3'b000) |=> (!evRdTrans && !evWrTrans && !evRdBeat));
endmodule

bind axi_id_event_filter axiflt_checker #(.ID_W(ID_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .arValid  (arValid),
  .arReady  (arReady),
  .arId     (arId),
  .awValid  (awValid),
  .awReady  (awReady),
  .awId     (awId),
  .rValid   (rValid),
  .rReady   (rReady),
  .rId      (rId),
  .enVec    (enVec),
  .idMask   (idMask),
  .matchId  (matchId),
  .evRdTrans(evRdTrans),
  .evWrTrans(evWrTrans),
  .evRdBeat (evRdBeat)
);

// File: tb/axi_id_event_filter_test.sv
`timescale 1ns/1ps
module axi_id_event_filter_test;
  localparam int ID_W = 4;
  localparam int ADDR_W = 8;

  logic clk = 1'b0;
  logic rstN;
  logic cfgWe;
  logic [ADDR_W-1:0] cfgAddr;
  logic [31:0] cfgWdata;
  logic arValid, arReady, awValid, awReady, rValid, rReady;
  logic [ID_W-1:0] arId, awId, rId;
  logic evRdTrans, evWrTrans, evRdBeat;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  // bench view of the programmed words, updated as they are written
  logic [31:0] mCtl = '0;
  logic [31:0] mId = '0;

  always #2 clk = ~clk;

  axi_id_event_filter #(.ID_W(ID_W), .ADDR_W(ADDR_W)) uut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .arValid(arValid), .arReady(arReady), .arId(arId),
    .awValid(awValid), .awReady(awReady), .awId(awId),
    .rValid(rValid), .rReady(rReady), .rId(rId),
    .evRdTrans(evRdTrans), .evWrTrans(evWrTrans), .evRdBeat(evRdBeat)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  function automatic logic hit(input logic en, input logic v, input logic r, input logic [ID_W-1:0] id);
    return en && v && r && (((id ^ mId[ID_W-1:0]) & mCtl[ID_W-1:0]) == '0);
  endfunction

  task automatic idle();
    arValid = 0; arReady = 0; awValid = 0; awReady = 0; rValid = 0; rReady = 0;
  endtask

  // one cycle of traffic; called at a falling edge, returns at the next falling edge
  task automatic hs(input logic av, input logic ar, input logic [ID_W-1:0] ai,
                    input logic wv, input logic wr, input logic [ID_W-1:0] wi,
                    input logic bv, input logic br, input logic [ID_W-1:0] bi,
                    input string req);
    logic eR, eW, eB;
    arValid = av; arReady = ar; arId = ai;
    awValid = wv; awReady = wr; awId = wi;
    rValid = bv; rReady = br; rId = bi;
    eR = hit(mCtl[31], av, ar, ai);
    eW = hit(mCtl[30], wv, wr, wi);
    eB = hit(mCtl[29], bv, br, bi);
    @(posedge clk);
    @(negedge clk);
    check(req, "evRdTrans", evRdTrans, eR);
    check(req, "evWrTrans", evWrTrans, eW);
    check(req, "evRdBeat", evRdBeat, eB);
  endtask

  task automatic cfgWrite(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    idle();
    cfgWe = 1; cfgAddr = a; cfgWdata = d;
    @(posedge clk);
    @(negedge clk);
    cfgWe = 0;
    if (a == 8'h00) mCtl = d;
    if (a == 8'h04) mId = d;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    rstN = 0; cfgWe = 0; cfgAddr = '0; cfgWdata = '0;
    arId = '0; awId = '0; rId = '0;
    idle();
    repeat (3) @(negedge clk);
    // R1: outputs low while in reset
    check("R1", "evRdTrans", evRdTrans, 1'b0);
    check("R1", "evWrTrans", evWrTrans, 1'b0);
    check("R1", "evRdBeat", evRdBeat, 1'b0);
    rstN = 1;
    @(negedge clk);
    // R1/R8: enables clear after reset, so full traffic gives no pulses
    hs(1, 1, 4'h5, 1, 1, 4'h0, 1, 1, 4'hF, "R1");

    // R3/R4/R5/R6/R10: every mask against every reference ID and every incoming ID
    for (int m = 0; m < 16; m++) begin
      for (int r = 0; r < 16; r++) begin
        cfgWrite(8'h00, {3'b111, 11'h5A5, 14'h0, 4'(m)});
        cfgWrite(8'h04, {28'hABCDEF1, 4'(r)});
        for (int a = 0; a < 16; a++) begin
          hs(1, 1, 4'(a), 1, 1, 4'(a) ^ 4'h9, 1, 1, 4'(a + 3), "R3 R4 R5 R6 R10");
        end
      end
    end

    // R7: valid and ready combinations, mask zero so every ID matches
    cfgWrite(8'h00, 32'hE000_0000);
    for (int c = 0; c < 4; c++) begin
      for (int s = 0; s < 4; s++) begin
        hs(c[0], c[1], 4'(s), s[0], s[1], 4'(c), c[1], s[0], 4'(c + s), "R7");
      end
    end

    // R8: every enable combination
    for (int e = 0; e < 8; e++) begin
      cfgWrite(8'h00, {3'(e), 29'h0});
      hs(1, 1, 4'h1, 1, 1, 4'h2, 1, 1, 4'h3, "R8");
    end

    // R2: writes to other offsets and to unused bits change nothing
    cfgWrite(8'h00, 32'hFFFF_FFFF);
    cfgWrite(8'h04, 32'hFFFF_FFF5);
    cfgWrite(8'h08, 32'h0000_0000);
    cfgWrite(8'h0C, 32'h0000_0000);
    cfgWrite(8'h40, 32'h0000_0000);
    hs(1, 1, 4'h5, 1, 1, 4'h5, 1, 1, 4'h5, "R2");
    hs(1, 1, 4'h4, 1, 1, 4'hD, 1, 1, 4'h7, "R2");

    // R9: a handshake in the cycle of a write uses the old settings
    arValid = 1; arReady = 1; arId = 4'h5;
    awValid = 0; awReady = 0; rValid = 0; rReady = 0;
    cfgWe = 1; cfgAddr = 8'h00; cfgWdata = 32'h0000_000F;
    @(posedge clk);
    @(negedge clk);
    cfgWe = 0;
    check("R9", "evRdTrans old settings", evRdTrans, 1'b1);
    mCtl = 32'h0000_000F;
    hs(1, 1, 4'h5, 0, 0, 4'h0, 0, 0, 4'h0, "R9");
    cfgWrite(8'h00, 32'hE000_000F);
    arValid = 1; arReady = 1; arId = 4'h5;
    cfgWe = 1; cfgAddr = 8'h04; cfgWdata = 32'h0000_0006;
    @(posedge clk);
    @(negedge clk);
    cfgWe = 0;
    check("R9", "evRdTrans old ID", evRdTrans, 1'b1);
    mId = 32'h0000_0006;
    hs(1, 1, 4'h5, 0, 0, 4'h0, 0, 0, 4'h0, "R9");

    // R6: back-to-back beats with one mismatch between them
    hs(0, 0, 4'h0, 0, 0, 4'h0, 1, 1, 4'h6, "R6");
    hs(0, 0, 4'h0, 0, 0, 4'h0, 1, 1, 4'h6, "R6");
    hs(0, 0, 4'h0, 0, 0, 4'h0, 1, 1, 4'h7, "R6");
    hs(0, 0, 4'h0, 0, 0, 4'h0, 1, 1, 4'h6, "R6");
    hs(0, 0, 4'h0, 0, 0, 4'h0, 0, 0, 4'h6, "R6");

    // R4/R5: single pulse per handshake, then quiet
    hs(1, 1, 4'h6, 1, 1, 4'h6, 0, 0, 4'h0, "R4 R5");
    hs(0, 1, 4'h6, 1, 0, 4'h6, 0, 0, 4'h0, "R4 R5");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule